// File: doc/BRIEF.md
# Configuration Startup Sequencer with Clock-Lock Stall

This block runs the last phase of device configuration. After a start request it walks through six startup cycles, one per startup-clock edge, and then enters user mode. User mode stays set until the next reset. A configuration input names one of the six cycles as a stall point. When the sequencer reaches that cycle it holds there until every clock manager that opted in to waiting reports lock. Clock managers that did not opt in have no effect on progress.

Each lock input crosses into the startup clock domain through a two-flop synchronizer. The combined lock condition must then hold on two consecutive startup clocks before the sequencer may leave the stall cycle. This means a one-clock lock pulse never releases the stall. If no manager has waiting enabled, the stall cycle passes in a single clock like any other cycle.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the registers come out of reset on the second clock edge after the reset input rises.

Top module: `cfg_startup_seq`

## Requirements
- R1: While reset is active, and until the sequencer is started, `step_o` is 0 and `stalled_o` and `user_mode_o` are 0.
- R2: `step_o` encodes the sequencer position: 0 means idle, k+1 means startup cycle k (k = 0..5), and 7 means user mode. A high `start_i` sampled while idle moves the sequencer to 1. From there it moves forward by exactly one per clock, and from 6 it moves to 7.
- R3: A `stall_sel_i` value s in 0..5 makes startup cycle s, shown as `step_o` = s+1, the stall point. The values 6 and 7 are clamped so that cycle 5 (`step_o` = 6) is the stall point.
- R4: A bit of `lock_i` whose `wait_en_i` bit is 0 has no effect on leaving the stall point, whether that lock bit is high or low.
- R5: Suppose all wait-enabled lock bits are high from before clock edge n and stay high. Then `stalled_o` drops after edge n+2, and the sequencer leaves the stall point on edge n+3.
- R6: `stalled_o` is 1 exactly while the sequencer sits at the stall point without a qualified lock. It is 0 in idle, in user mode, and at every other cycle.
- R7: With `wait_en_i` all zero, the stall point passes in one clock, and the sequence from 1 to 7 takes seven clocks.
- R8: `user_mode_o` is sticky until reset. In user mode, `start_i`, `lock_i`, `wait_en_i` and `stall_sel_i` do not change any output.
- R9: If the wait-enabled lock bits are high for only one clock, the sequencer does not leave the stall point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, taken only while idle |
| stall_sel_i | input | 3 | Index of the startup cycle used as the stall point (values above 5 are clamped) |
| wait_en_i | input | 4 | Per-manager enable for waiting on lock |
| lock_i | input | 4 | Per-manager lock status, asynchronous to the startup clock |
| step_o | output | 3 | Sequencer position: 0 idle, 1..6 startup cycles, 7 user mode |
| stalled_o | output | 1 | High while held at the stall point waiting for lock |
| user_mode_o | output | 1 | Sticky user-mode flag |

## Verification
The critical collision is lock qualification finishing on the same edge on which the sequencer arrives at the stall point. The opposite case also needs attention: a lock bit dropping on the very edge where the sequencer would otherwise leave the stall point. Directed cases pin the exact three-edge release latency, the single-clock lock pulse, and the clamped stall select. Long constrained-random runs then toggle the lock and wait-enable bits, change the select and issue start requests while the sequencer moves, so both collisions arise many times. Every cycle's step, stall and user-mode outputs are judged against a bench model written from the requirements.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_USER = 2'd2
  } seq_phase_t;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/lock_gate.sv
module lock_gate #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wait_en_i,
  input  logic [W-1:0] lock_s_i,
  output logic         lock_ok_o
);
  logic all_met;
  logic met_q;

  // a manager that does not wait counts as locked
  always_comb begin
    all_met = &(lock_s_i | ~wait_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) met_q <= 1'b0;
    else        met_q <= all_met;
  end

  assign lock_ok_o = all_met & met_q;
endmodule

// File: rtl/step_fsm.sv
module step_fsm
  import startup_seq_pkg::*;
#(
  parameter int unsigned N_STEPS = 6,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  stall_sel_i,
  input  logic              lock_ok_i,
  output logic [STEP_W-1:0] step_o,
  output logic              stalled_o,
  output logic              user_o
);
  localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(N_STEPS - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS);
  localparam logic [STEP_W-1:0] USER_CODE = STEP_W'(N_STEPS + 1);
  localparam logic [STEP_W-1:0] ONE       = STEP_W'(1);

  seq_phase_t        phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [SEL_W-1:0]  sel_c;
  logic [STEP_W-1:0] stall_step;
  logic              at_stall;
  logic              advance;
  logic              reg_en;

  always_comb begin
    sel_c      = (stall_sel_i > LAST_SEL) ? LAST_SEL : stall_sel_i;
    stall_step = STEP_W'(sel_c) + ONE;
    at_stall   = (phase_q == PH_RUN) && (step_q == stall_step);
    advance    = !at_stall || lock_ok_i;
  end

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_RUN;
          step_d  = ONE;
        end
      end
      PH_RUN: begin
        if (advance) begin
          if (step_q == LAST_STEP) begin
            phase_d = PH_USER;
            step_d  = USER_CODE;
          end else begin
            step_d = step_q + ONE;
          end
        end
      end
      default: ;
    endcase
    reg_en = (phase_d != phase_q) || (step_d != step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else if (reg_en) begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

  assign step_o    = step_q;
  assign stalled_o = at_stall && !lock_ok_i;
  assign user_o    = (phase_q == PH_USER);

  // R2: while running, position moves by at most one per clock
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |=> (step_q == $past(step_q) || step_q == $past(step_q) + ONE));

  // R2: leaving idle always lands on the first cycle
  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start_i) |=> (step_q == ONE));

  // R3: no qualified lock at the stall point means no movement
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_stall && !lock_ok_i) |=> (step_q == $past(step_q)));

  // R8: user mode is never left without reset
  assert_user_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    user_o |=> (user_o && step_q == USER_CODE));

  // R6: stall indication never coexists with user mode or idle
  assert_stall_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stalled_o |-> (!user_o && step_q != '0));
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
  parameter int unsigned N_MGR   = 4,
  parameter int unsigned N_STEPS = 6,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned STEP_W = $clog2(N_STEPS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  stall_sel_i,
  input  logic [N_MGR-1:0]  wait_en_i,
  input  logic [N_MGR-1:0]  lock_i,
  output logic [STEP_W-1:0] step_o,
  output logic              stalled_o,
  output logic              user_mode_o
);
  logic             rst_meta_q;
  logic             rst_int_n;
  logic [N_MGR-1:0] lock_s;
  logic             lock_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  lock_sync #(.W(N_MGR)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (lock_i),
    .sync_o  (lock_s)
  );

  lock_gate #(.W(N_MGR)) u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wait_en_i (wait_en_i),
    .lock_s_i  (lock_s),
    .lock_ok_o (lock_ok)
  );

  step_fsm #(.N_STEPS(N_STEPS), .SEL_W(SEL_W), .STEP_W(STEP_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .stall_sel_i (stall_sel_i),
    .lock_ok_i   (lock_ok),
    .step_o      (step_o),
    .stalled_o   (stalled_o),
    .user_o      (user_mode_o)
  );
endmodule

// File: tb/test_cfg_startup_seq.sv
module test_cfg_startup_seq;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [2:0] stall_sel_i;
  logic [3:0] wait_en_i;
  logic [3:0] lock_i;
  logic [2:0] step_o;
  logic       stalled_o;
  logic       user_mode_o;

  int n_chk;
  int n_bad;
  bit done;

  cfg_startup_seq i_cfg_startup_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stall_sel_i (stall_sel_i),
    .wait_en_i   (wait_en_i),
    .lock_i      (lock_i),
    .step_o      (step_o),
    .stalled_o   (stalled_o),
    .user_mode_o (user_mode_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // requirement model
  bit       m_rs1, m_rs2, m_metq;
  bit [3:0] m_s1, m_s2;
  int       m_ph;   // 0 idle, 1 running, 2 user
  int       m_step;

  function automatic int stall_pos(input logic [2:0] sel);
    return ((sel > 3'd5) ? 5 : int'(sel)) + 1;
  endfunction

  function automatic bit exp_ok();
    return (&(m_s2 | ~wait_en_i)) && m_metq;
  endfunction

  function automatic bit exp_stalled();
    return (m_ph == 1) && (m_step == stall_pos(stall_sel_i)) && !exp_ok();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_s1 = '0; m_s2 = '0; m_metq = 0; m_ph = 0; m_step = 0;
    end else begin
      bit       o_rs1, o_rs2, ok, met;
      bit [3:0] o_s1;
      o_rs1 = m_rs1; o_rs2 = m_rs2; o_s1 = m_s1;
      met = &(m_s2 | ~wait_en_i);
      ok  = exp_ok();
      m_rs1 = 1; m_rs2 = o_rs1;
      if (o_rs2) begin
        if (m_ph == 0) begin
          if (start_i) begin m_ph = 1; m_step = 1; end
        end else if (m_ph == 1) begin
          if (m_step != stall_pos(stall_sel_i) || ok) begin
            if (m_step == 6) begin m_ph = 2; m_step = 7; end
            else m_step = m_step + 1;
          end
        end
        m_s1 = lock_i; m_s2 = o_s1; m_metq = met;
      end
    end
  end

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_model(input string tag);
    check_val(tag, "step_o", int'(step_o), m_step);
    check_val(tag, "stalled_o", int'(stalled_o), int'(exp_stalled()));
    check_val(tag, "user_mode_o", int'(user_mode_o), (m_ph == 2) ? 1 : 0);
  endtask

  // one clock edge, then compare at the following falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_model(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_i = 0;
    @(negedge clk);
    check_model("R1");
    rst_n = 1'b1;
    tick("R1"); tick("R1");
    tick("R1");
    check_val("R1", "idle step", int'(step_o), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; start_i = 0; stall_sel_i = 3'd2; wait_en_i = '0; lock_i = '0;
    repeat (2) @(negedge clk);
    check_val("R1", "step_o in reset", int'(step_o), 0);
    check_val("R1", "stalled_o in reset", int'(stalled_o), 0);
    check_val("R1", "user_mode_o in reset", int'(user_mode_o), 0);
    rst_n = 1'b1;
    repeat (3) tick("R1");

    // R7 / R2: no manager waits, full walk one step per clock
    start_i = 1;
    tick("R2");
    check_val("R2", "first step", int'(step_o), 1);
    start_i = 0;
    for (int k = 2; k <= 7; k++) begin
      tick("R7");
      check_val("R7", "walk step", int'(step_o), k);
      check_val("R7", "no stall", int'(stalled_o), 0);
    end
    check_val("R8", "user set", int'(user_mode_o), 1);
    // R8: inputs in user mode change nothing
    start_i = 1; lock_i = 4'hF; wait_en_i = 4'hF; stall_sel_i = 3'd0;
    repeat (4) tick("R8");
    lock_i = 4'h0;
    repeat (4) tick("R8");
    check_val("R8", "user sticky step", int'(step_o), 7);
    check_val("R8", "user sticky flag", int'(user_mode_o), 1);

    // R3 / R4 / R5 / R6: stall at cycle 3, only manager 0 waits
    stall_sel_i = 3'd3; wait_en_i = 4'b0001; lock_i = 4'b1110; start_i = 0;
    do_reset();
    start_i = 1; tick("R2"); start_i = 0;
    repeat (8) tick("R4");
    check_val("R3", "held at stall", int'(step_o), 4);
    check_val("R6", "stalled high", int'(stalled_o), 1);
    lock_i = 4'b0001;   // disabled managers drop, the waiting one locks
    tick("R5"); check_val("R5", "edge n step", int'(step_o), 4);
    tick("R5"); check_val("R5", "edge n+1 stalled", int'(stalled_o), 1);
    tick("R5"); check_val("R5", "edge n+2 stalled", int'(stalled_o), 0);
    check_val("R5", "edge n+2 step", int'(step_o), 4);
    tick("R5"); check_val("R5", "edge n+3 step", int'(step_o), 5);
    check_val("R4", "disabled ignored", int'(step_o), 5);

    // R9: one-clock lock pulse, stall at cycle 0
    stall_sel_i = 3'd0; wait_en_i = 4'hF; lock_i = 4'h0;
    do_reset();
    start_i = 1; tick("R2"); start_i = 0;
    check_val("R9", "at stall", int'(stalled_o), 1);
    lock_i = 4'hF; tick("R9");
    lock_i = 4'h0;
    repeat (6) tick("R9");
    check_val("R9", "pulse no release", int'(step_o), 1);
    check_val("R9", "pulse still stalled", int'(stalled_o), 1);

    // R3 clamp: select 7 stalls at cycle 5
    stall_sel_i = 3'd7; wait_en_i = 4'b0010; lock_i = 4'b0000;
    do_reset();
    start_i = 1; tick("R2"); start_i = 0;
    repeat (8) tick("R3");
    check_val("R3", "clamped stall", int'(step_o), 6);
    check_val("R6", "clamped stalled", int'(stalled_o), 1);
    lock_i = 4'b0010;
    repeat (4) tick("R5");
    check_val("R8", "user after clamp", int'(user_mode_o), 1);
    lock_i = 4'b0000;
    repeat (3) tick("R8");
    check_val("R8", "still user", int'(user_mode_o), 1);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 249) == 0) begin
        rst_n = 1'b0;
        @(negedge clk);
        check_model("R1");
        rst_n = 1'b1;
      end
      start_i = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 39) == 0) stall_sel_i = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 59) == 0) wait_en_i = 4'($urandom_range(0, 15));
      for (int b = 0; b < 4; b++)
        if ($urandom_range(0, 5) == 0) lock_i[b] = ~lock_i[b];
      tick("R5");
    end

    finish_up();
  end
endmodule